// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block guards a system against a hung processor. Once software turns it on, a down-counter runs from a programmable timeout, and software has to restart it in time by writing a fixed key byte. If the counter reaches its end, the block either asserts a system reset pulse straight away or first raises an interrupt. In the two-stage case the reset follows only when a second timeout passes while that interrupt is still pending.

Software reaches the block over a zero-wait-state APB-style register bus. `psel` together with `penable` marks a valid transfer. `pready` is the ready side and is tied high, so the bus never sees back-pressure and every access finishes in its access cycle. Two 4-bit codes set the timeouts: one is loaded when the block is first turned on, and the other is used after every restart and every expiry. Each code picks a power-of-two period. The reset pulse is active high, and its width is a power of two bus clock cycles.

Register map (byte offsets): 0x00 control, 0x04 timeout codes, 0x08 live count (read-only), 0x0C restart key (write-only), 0x10 interrupt status, 0x14 interrupt acknowledge (read to clear).

Top module: `watchdog_timer`

## Requirements
- R1: After reset, `irq` and `sys_rst` are low and reads of control (0x00), count (0x08) and status (0x10) return 0. Control bits [4:2], [1] and timeout bits [7:0] read back as written.
- R2: Writing control bit 0 as 1 turns the block on. A write of 0 cannot clear it; only reset can. At that write the counter loads 2^(BASE_EXP+F)-1, where F is timeout bits [7:4]. It then decreases by one each cycle, and offset 0x08 returns its value.
- R3: The first expiry comes 2^(BASE_EXP+F) cycles after the enabling write. Every later period is 2^(BASE_EXP+L) cycles, where L is timeout bits [3:0].
- R4: With control bit 1 at 0, each expiry starts a reset pulse and never raises `irq`.
- R5: With control bit 1 at 1, an expiry with no interrupt pending sets `irq` (status bit 0) and reloads the counter. An expiry with the interrupt pending starts a reset pulse and clears the interrupt.
- R6: Writing 0x76 in the low byte of offset 0x0C reloads 2^(BASE_EXP+L)-1 and clears the interrupt. Any other value there has no effect.
- R7: Reading offset 0x14 clears the pending interrupt and leaves the counter running. The next expiry then raises the interrupt again rather than resetting.
- R8: `sys_rst` is active high for exactly 2^(C+1) cycles, where C is control bits [4:2] (2 to 256 cycles).
- R9: While the block is off, the counter holds 0, no output is asserted and restart writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Transfer select (valid, with penable) |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1: no wait states |
| irq | output | 1 | Pending watchdog interrupt |
| sys_rst | output | 1 | System reset pulse, active high |

## Verification
Directed runs cover each response mode on its own: immediate reset, interrupt and then reset, interrupt acknowledged and raised again, and a restart that clears the interrupt. Together these separate the pending-interrupt decision from the plain expiry path. A sweep over all eight width codes pins down the pulse length. Live-count reads taken after a good key and after a wrong key show whether a reload really happened. Randomised runs mix the first and later timeout codes, the mode and the width. They check that the first period and the later periods each use their own code, so swapped or shared codes are caught.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // byte offsets of the register slots
  localparam int unsigned OFF_CTRL = 32'h00;
  localparam int unsigned OFF_TMO  = 32'h04;
  localparam int unsigned OFF_CNT  = 32'h08;
  localparam int unsigned OFF_KICK = 32'h0C;
  localparam int unsigned OFF_STAT = 32'h10;
  localparam int unsigned OFF_ACK  = 32'h14;

  localparam logic [7:0] KICK_KEY = 8'h76;

  // control: [4:2] pulse width code, [1] two-stage mode, [0] enable
  typedef struct packed {
    logic [2:0] pulse_code;
    logic       irq_mode;
    logic       enable;
  } ctrl_t;

  // timeout codes: [7:4] first period, [3:0] later periods
  typedef struct packed {
    logic [3:0] first_code;
    logic [3:0] later_code;
  } tmo_t;

  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_TMO,
    SEL_CNT,
    SEL_KICK,
    SEL_STAT,
    SEL_ACK,
    SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/wdt_regbus.sv
module wdt_regbus
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              irq_pend,
  output ctrl_t             ctrl_q,
  output tmo_t              tmo_q,
  output logic              start_p,
  output logic              kick_p,
  output logic              ack_p
);

  reg_sel_e sel;
  logic     wr_acc;
  logic     rd_acc;
  logic     unused_hi;

  assign unused_hi = &{1'b0, pwdata[31:8]};
  assign wr_acc    = psel & penable & pwrite;
  assign rd_acc    = psel & penable & ~pwrite;

  always_comb begin
    case (paddr)
      ADDR_W'(OFF_CTRL): sel = SEL_CTRL;
      ADDR_W'(OFF_TMO):  sel = SEL_TMO;
      ADDR_W'(OFF_CNT):  sel = SEL_CNT;
      ADDR_W'(OFF_KICK): sel = SEL_KICK;
      ADDR_W'(OFF_STAT): sel = SEL_STAT;
      ADDR_W'(OFF_ACK):  sel = SEL_ACK;
      default:           sel = SEL_NONE;
    endcase
  end

  // one-cycle strobes toward the counter, taking effect at the access edge
  assign start_p = wr_acc && (sel == SEL_CTRL) && pwdata[0] && !ctrl_q.enable;
  assign kick_p  = wr_acc && (sel == SEL_KICK) && (pwdata[7:0] == KICK_KEY)
                   && ctrl_q.enable;
  assign ack_p   = rd_acc && (sel == SEL_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tmo_q  <= '0;
    end else if (wr_acc) begin
      if (sel == SEL_CTRL) begin
        ctrl_q.enable     <= ctrl_q.enable | pwdata[0];
        ctrl_q.irq_mode   <= pwdata[1];
        ctrl_q.pulse_code <= pwdata[4:2];
      end
      if (sel == SEL_TMO) begin
        tmo_q <= tmo_t'(pwdata[7:0]);
      end
    end
  end

  always_comb begin
    prdata = '0;
    case (sel)
      SEL_CTRL: prdata = 32'(ctrl_q);
      SEL_TMO:  prdata = 32'(tmo_q);
      SEL_CNT:  prdata = 32'(cnt_val);
      SEL_STAT: prdata = {31'b0, irq_pend};
      default:  prdata = '0;
    endcase
  end

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int BASE_EXP = 16,
  parameter int CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             irq_mode,
  input  logic [3:0]       first_code,
  input  logic [3:0]       later_code,
  input  logic             start_p,
  input  logic             kick_p,
  input  logic             ack_p,
  output logic [CNT_W-1:0] count_q,
  output logic             irq_q,
  output logic             fire
);

  logic expire;

  function automatic logic [CNT_W-1:0] reload_of(input logic [3:0] code);
    return (CNT_W'(1) << (BASE_EXP + int'(code))) - CNT_W'(1);
  endfunction

  // a restart in the same cycle wins over an expiry
  assign expire = enable && (count_q == '0) && !kick_p && !start_p;
  assign fire   = expire && (!irq_mode || irq_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (start_p) begin
      count_q <= reload_of(first_code);
    end else if (kick_p) begin
      count_q <= reload_of(later_code);
    end else if (enable) begin
      if (count_q == '0) count_q <= reload_of(later_code);
      else               count_q <= count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (kick_p) begin
      irq_q <= 1'b0;
    end else if (expire) begin
      irq_q <= irq_mode && !irq_q;
    end else if (ack_p) begin
      irq_q <= 1'b0;
    end
  end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [CODE_W-1:0] code,
  output logic              active
);

  localparam int REM_W = (1 << CODE_W) + 1;

  logic [REM_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (fire) begin
      rem_q <= REM_W'(1) << (int'(code) + 1);
    end else if (rem_q != '0) begin
      rem_q <= rem_q - REM_W'(1);
    end
  end

  assign active = (rem_q != '0);

endmodule

// File: rtl/watchdog_timer.sv
module watchdog_timer
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BASE_EXP = 16,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              irq,
  output logic              sys_rst
);

  ctrl_t            ctrl_q;
  tmo_t             tmo_q;
  logic             start_p;
  logic             kick_p;
  logic             ack_p;
  logic [CNT_W-1:0] count_val;
  logic             irq_pend;
  logic             fire;

  assign pready = 1'b1;

  wdt_regbus #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regbus (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .prdata   (prdata),
    .cnt_val  (count_val),
    .irq_pend (irq_pend),
    .ctrl_q   (ctrl_q),
    .tmo_q    (tmo_q),
    .start_p  (start_p),
    .kick_p   (kick_p),
    .ack_p    (ack_p)
  );

  wdt_core #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (ctrl_q.enable),
    .irq_mode   (ctrl_q.irq_mode),
    .first_code (tmo_q.first_code),
    .later_code (tmo_q.later_code),
    .start_p    (start_p),
    .kick_p     (kick_p),
    .ack_p      (ack_p),
    .count_q    (count_val),
    .irq_q      (irq_pend),
    .fire       (fire)
  );

  wdt_pulse #(.CODE_W(3)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .code   (ctrl_q.pulse_code),
    .active (sys_rst)
  );

  assign irq = irq_pend;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int BASE_EXP = 16,
  parameter int CNT_W    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             irq_mode,
  input logic [2:0]       pulse_code,
  input logic [3:0]       later_code,
  input logic             kick,
  input logic [CNT_W-1:0] count,
  input logic             irq,
  input logic             sys_rst
);

  logic [CNT_W-1:0] kick_val;
  logic             prev_rst;
  logic [9:0]       hi_len;
  logic [9:0]       exp_len;

  assign kick_val = (CNT_W'(1) << (BASE_EXP + int'(later_code))) - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rst <= 1'b0;
      hi_len   <= '0;
      exp_len  <= '0;
    end else begin
      prev_rst <= sys_rst;
      if (sys_rst && !prev_rst) begin
        hi_len  <= 10'd1;
        exp_len <= 10'd1 << (int'(pulse_code) + 1);
      end else if (sys_rst) begin
        hi_len <= hi_len + 10'd1;
      end
    end
  end

  assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> enable);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !kick && (count != '0) |=> count == $past(count) - CNT_W'(1));

  assert_no_irq_mode0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && !irq_mode |=> !irq);

  assert_reset_after_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) && $past(irq_mode) |-> $past(irq) && !irq);

  assert_kick_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (count == $past(kick_val)) && !irq);

  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> hi_len == exp_len);

  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (count == '0) && !irq && !sys_rst);

endmodule

bind watchdog_timer wdt_checker #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) i_wdt_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (ctrl_q.enable),
  .irq_mode   (ctrl_q.irq_mode),
  .pulse_code (ctrl_q.pulse_code),
  .later_code (tmo_q.later_code),
  .kick       (kick_p),
  .count      (count_val),
  .irq        (irq),
  .sys_rst    (sys_rst)
);

// File: tb/test_watchdog_timer.sv
module test_watchdog_timer;

  localparam int CLK_PERIOD = 10;
  localparam int TB_BASE    = 6;
  localparam int ADDR_W     = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              psel = 1'b0;
  logic              penable = 1'b0;
  logic              pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0]       pwdata = '0;
  logic [31:0]       prdata;
  logic              pready;
  logic              irq;
  logic              sys_rst;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  watchdog_timer #(.ADDR_W(ADDR_W), .BASE_EXP(TB_BASE), .CNT_W(32)) i_watchdog_timer (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .irq(irq), .sys_rst(sys_rst)
  );

  function automatic int period(input int code);
    return 1 << (TB_BASE + code);
  endfunction

  function automatic int width(input int code);
    return 1 << (code + 1);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apb_write(input int addr, input int data, output int t);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0;
    paddr = ADDR_W'(addr); pwdata = 32'(data);
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    t = cyc;
  endtask

  task automatic apb_read(input int addr, output int data, output int t);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = ADDR_W'(addr);
    @(negedge clk);
    penable = 1'b1;
    #1;
    data = int'(prdata);
    t = cyc;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wait_for(input bit want_irq, input int limit, output int t);
    t = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (want_irq ? irq : sys_rst) begin
        t = cyc;
        break;
      end
    end
  endtask

  task automatic measure_width(output int w);
    w = 0;
    while (sys_rst && w < 1000) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int d, t0, t1, tk, ti, w;
    void'($urandom(32'd20240611));
    do_reset();

    // R1 / R9: reset state, idle block ignores restart
    chk("R1", "irq after reset", irq, 0);
    chk("R1", "sys_rst after reset", sys_rst, 0);
    chk("R1", "pready", pready, 1);
    apb_read(32'h00, d, t1); chk("R1", "ctrl after reset", d, 0);
    apb_read(32'h08, d, t1); chk("R1", "count after reset", d, 0);
    apb_read(32'h10, d, t1); chk("R1", "status after reset", d, 0);
    apb_write(32'h0C, 32'h76, t1);
    repeat (5) @(negedge clk);
    apb_read(32'h08, d, t1); chk("R9", "count stays 0 while off", d, 0);
    chk("R9", "no reset while off", sys_rst, 0);

    // R2/R3/R4/R8: immediate reset mode, first code 1, later code 0, width code 1
    apb_write(32'h04, 32'h10, t1);
    apb_read(32'h04, d, t1); chk("R1", "timeout codes read back", d, 32'h10);
    apb_write(32'h00, 32'h05, t0);
    apb_read(32'h00, d, t1); chk("R1", "ctrl read back", d, 32'h05);
    apb_read(32'h08, d, t1); chk("R2", "live count", d, period(1) - 1 - (t1 - t0));
    wait_for(1'b0, 1000, t1);
    chk("R3", "first expiry time", t1 - t0, period(1));
    chk("R4", "no irq in reset mode", irq, 0);
    measure_width(w); chk("R8", "width code 1", w, width(1));
    wait_for(1'b0, 1000, tk);
    chk("R3", "later period", tk - t1, period(0));
    measure_width(w);
    apb_write(32'h00, 32'h00, t1);
    apb_read(32'h00, d, t1); chk("R2", "enable cannot be cleared", d & 1, 1);

    // R6: good key reloads, wrong key ignored
    do_reset();
    apb_write(32'h04, 32'h21, t1);
    apb_write(32'h00, 32'h01, t0);
    repeat (100) @(negedge clk);
    apb_write(32'h0C, 32'h76, tk);
    apb_read(32'h08, d, t1); chk("R6", "count after good key", d, period(1) - 1 - (t1 - tk));
    apb_write(32'h0C, 32'h75, t1);
    apb_read(32'h08, d, t1); chk("R6", "count after wrong key", d, period(1) - 1 - (t1 - tk));
    wait_for(1'b0, 1000, t1);
    chk("R6", "expiry measured from restart", t1 - tk, period(1));
    measure_width(w);

    // R5: interrupt then reset
    do_reset();
    apb_write(32'h04, 32'h10, t1);
    apb_write(32'h00, 32'h0B, t0);
    wait_for(1'b1, 1000, ti);
    chk("R5", "irq at first expiry", ti - t0, period(1));
    chk("R5", "no reset at first expiry", sys_rst, 0);
    apb_read(32'h10, d, t1); chk("R5", "status bit 0 set", d, 1);
    wait_for(1'b0, 1000, t1);
    chk("R5", "reset at second expiry", t1 - ti, period(0));
    chk("R5", "irq cleared with reset", irq, 0);
    measure_width(w); chk("R8", "width code 2", w, width(2));

    // R7: acknowledge clears irq, counter keeps running
    do_reset();
    apb_write(32'h04, 32'h10, t1);
    apb_write(32'h00, 32'h03, t0);
    wait_for(1'b1, 1000, ti);
    apb_read(32'h14, d, t1);
    @(negedge clk);
    chk("R7", "irq cleared by ack", irq, 0);
    apb_read(32'h10, d, t1); chk("R7", "status after ack", d, 0);
    apb_read(32'h08, d, t1); chk("R7", "count not restarted", d, period(0) - 1 - (t1 - ti));
    wait_for(1'b1, 1000, t1);
    chk("R7", "irq raised again", t1 - ti, period(0));
    chk("R7", "no reset after ack", sys_rst, 0);
    apb_write(32'h0C, 32'h76, tk);
    chk("R6", "good key clears irq", irq, 0);

    // R8: every width code
    for (int c = 0; c < 8; c++) begin
      do_reset();
      apb_write(32'h04, 32'h03, t1);
      apb_write(32'h00, (c << 2) | 1, t0);
      wait_for(1'b0, 1000, t1);
      chk("R3", "first expiry in width sweep", t1 - t0, period(0));
      measure_width(w);
      chk("R8", "width sweep", w, width(c));
    end

    // random mixes of codes, modes and widths
    for (int k = 0; k < 14; k++) begin
      int fc, lc, md, pc;
      fc = int'($urandom % 3);
      lc = int'($urandom % 3);
      md = int'($urandom % 2);
      pc = int'($urandom % 4);
      do_reset();
      apb_write(32'h04, (fc << 4) | lc, t1);
      apb_write(32'h00, (pc << 2) | (md << 1) | 1, t0);
      d = int'($urandom % 40);
      repeat (d) @(negedge clk);
      apb_read(32'h08, d, t1);
      chk("R2", "random live count", d, period(fc) - 1 - (t1 - t0));
      if (md == 0) begin
        wait_for(1'b0, 2000, t1);
        chk("R3", "random first expiry", t1 - t0, period(fc));
        measure_width(w); chk("R8", "random width", w, width(pc));
        wait_for(1'b0, 2000, tk);
        chk("R3", "random later period", tk - t1, period(lc));
        chk("R4", "random no irq", irq, 0);
        measure_width(w);
      end else begin
        wait_for(1'b1, 2000, ti);
        chk("R5", "random irq time", ti - t0, period(fc));
        wait_for(1'b0, 2000, t1);
        chk("R5", "random reset time", t1 - ti, period(lc));
        measure_width(w); chk("R8", "random width", w, width(pc));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule